// File: doc/BRIEF.md
# Frame-Locked Conversion Slot Sequencer

This block paces a repeating acquisition frame that an external field-rate pulse (nominally 50 Hz) locks in place. It divides the 4 MHz core clock into a slow serial bit clock for the attached acquisition peripherals. It cuts each frame into a fixed number of conversion slots of equal length, 96 slots of 833 clocks by default. The slots end a little before the next pulse, and the sequencer then waits in a tail state until the next rising edge of the field input restarts slot 0, the slot timer and the bit-clock divider together.

In each slot the block makes four accesses to a shared frame buffer through a request/grant handshake. It first reads the slot's control word and then its upper/lower routing bit. Near the end of the slot it writes the received data word and then the auxiliary word. A buffer address is made of a half-select bit, the slot number and a 3-bit word selector. The half-select bit flips on every field pulse, so software can always read the half the hardware is not filling. If a slot ends while one of its accesses is still waiting for a grant, the block sets a sticky overrun flag.

The frame state machine has three states. FR_WAIT_SYNC is the state after reset, before any pulse. FR_RUN is the state while slots are running. FR_TAIL is the state after the last slot. Its transitions are: a field rise leads from any state to FR_RUN; the end of the last slot leads from FR_RUN to FR_TAIL. The access state machine has these states: AC_IDLE, AC_RD_CTRL, AC_RD_UL, AC_WAIT_WR, AC_WR_DATA, AC_WR_AUX and AC_DONE. Its transitions are:
- AC_IDLE goes to AC_RD_CTRL at the first tick of a slot.
- AC_RD_CTRL and AC_RD_UL each advance on a grant, and AC_RD_UL then goes to AC_WAIT_WR.
- AC_WAIT_WR goes to AC_WR_DATA once the write window is open.
- AC_WR_DATA and AC_WR_AUX each advance on a grant, and AC_WR_AUX then goes to AC_DONE.
- Every state returns to AC_IDLE at the end of a slot or on a field rise.

Top module: `conv_seq`

## Requirements
- R1: `bit_clk` has a period of PRESCALE clocks and is high for the first PRESCALE/2 of them. Its phase restarts on a field rise, so the cycle after the rise edge is phase 0.
- R2: Only a rising edge of `field_in` starts a frame. With no pulse after reset, or while `field_in` stays high, the block starts nothing new. A rise during a frame restarts it at slot 0, tick 0.
- R3: `slot_idx` counts from 0 and advances by one every SLOT_CLKS clocks while the frame runs.
- R4: After SLOT_CLKS clocks of slot NUM_SLOTS-1, `frame_active` goes low and `mem_req` stays low until the next field rise. Both are also low before the first rise.
- R5: `fill_half` is 0 after reset and inverts on every field rise.
- R6: `mem_addr` is {fill_half, slot_idx, word_sel[2:0]}, where word_sel is 0 for the control word, 1 for the upper/lower bit, 2 for the data word and 3 for the auxiliary word.
- R7: Each slot first reads word 0 and then word 1. The first request appears at tick 1 of the slot. A request stays high with a steady address until a cycle in which `mem_gnt` is high.
- R8: The data write (word 2) and then the auxiliary write (word 3) come only at tick SLOT_CLKS-WR_WIN+1 or later, and at least one cycle after the word-1 grant. `mem_we` is high for them, and `mem_wdata` carries `data_in` or `aux_in`.
- R9: On the grant of word 0, `ctrl_word` takes `mem_rdata`. On the grant of word 1, `ctrl_upper` takes `mem_rdata[0]`.
- R10: `overrun` becomes 1 after the last tick of a slot in which not all four accesses were granted, and it stays 1 until reset.
- R11: A field rise while an access is pending drops that access without setting `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock (4 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_in | input | 1 | Field-rate sync level; its rising edge starts a frame |
| mem_gnt | input | 1 | Buffer grant for the current request |
| mem_rdata | input | DW | Read data, valid with the grant |
| data_in | input | DW | Received data word to store |
| aux_in | input | DW | Received auxiliary word to store |
| bit_clk | output | 1 | Serial bit clock for the peripherals |
| frame_active | output | 1 | High while slots are running |
| slot_idx | output | SW | Current conversion slot |
| fill_half | output | 1 | Buffer half being filled; the other half is stable |
| mem_req | output | 1 | Buffer access request |
| mem_we | output | 1 | High for a write access |
| mem_addr | output | AW | Buffer word address |
| mem_wdata | output | DW | Write data on the internal bus |
| ctrl_word | output | DW | Last control word read |
| ctrl_upper | output | 1 | Last upper/lower routing bit read |
| overrun | output | 1 | Sticky missed-grant flag |

## Verification
The properties assume that `mem_gnt` matters only while `mem_req` is high. They also assume that field rises come no faster than the tail allows, so that a frame normally completes, although an early rise is legal and the checks stay valid across it. The stimulus drives `mem_gnt` and `mem_rdata` only on the falling clock edge. It spaces field pulses by a random amount just past the frame length, and adds directed cases for an early pulse, a pulse held high, a withheld grant at a write and a slot with no grants at all.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        FR_WAIT_SYNC = 2'd0,
        FR_RUN       = 2'd1,
        FR_TAIL      = 2'd2
    } frame_state_t;

    typedef enum logic [2:0] {
        AC_IDLE    = 3'd0,
        AC_RD_CTRL = 3'd1,
        AC_RD_UL   = 3'd2,
        AC_WAIT_WR = 3'd3,
        AC_WR_DATA = 3'd4,
        AC_WR_AUX  = 3'd5,
        AC_DONE    = 3'd6
    } acc_state_t;

    localparam int WSEL_W = 3;
    localparam logic [WSEL_W-1:0] WS_CTRL = 3'd0;
    localparam logic [WSEL_W-1:0] WS_UL   = 3'd1;
    localparam logic [WSEL_W-1:0] WS_DATA = 3'd2;
    localparam logic [WSEL_W-1:0] WS_AUX  = 3'd3;

endpackage

// File: rtl/cs_prescaler.sv
module cs_prescaler #(
    parameter int DIV = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic bit_clk
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] PH_LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] PH_HALF = CW'(DIV / 2);

    logic [CW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || phase == PH_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        bit_clk = (phase < PH_HALF);
    end
endmodule

// File: rtl/cs_frame_timer.sv
module cs_frame_timer
    import conv_seq_pkg::*;
#(
    parameter int SLOT_CLKS = 833,
    parameter int NUM_SLOTS = 96,
    parameter int WR_WIN    = 16,
    localparam int TW = $clog2(SLOT_CLKS),
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [TW-1:0] tick,
    output logic [SW-1:0] slot,
    output logic          active,
    output logic          slot_first,
    output logic          slot_last,
    output logic          wr_zone
);
    localparam logic [TW-1:0] T_LAST = TW'(SLOT_CLKS - 1);
    localparam logic [TW-1:0] T_WR   = TW'(SLOT_CLKS - WR_WIN);
    localparam logic [SW-1:0] S_LAST = SW'(NUM_SLOTS - 1);

    frame_state_t st, st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= FR_WAIT_SYNC;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        if (restart) begin
            st_nx = FR_RUN;
        end else begin
            unique case (st)
                FR_WAIT_SYNC: st_nx = FR_WAIT_SYNC;
                FR_RUN: begin
                    if (tick == T_LAST && slot == S_LAST) begin
                        st_nx = FR_TAIL;
                    end
                end
                FR_TAIL:      st_nx = FR_TAIL;
                default:      st_nx = FR_WAIT_SYNC;
            endcase
        end
    end

    // slot timer and conversion counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= '0;
            slot <= '0;
        end else if (restart) begin
            tick <= '0;
            slot <= '0;
        end else if (st == FR_RUN) begin
            if (tick == T_LAST) begin
                tick <= '0;
                if (slot != S_LAST) begin
                    slot <= slot + 1'b1;
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        active     = (st == FR_RUN);
        slot_first = (st == FR_RUN) && (tick == '0);
        slot_last  = (st == FR_RUN) && (tick == T_LAST);
        wr_zone    = (st == FR_RUN) && (tick >= T_WR);
    end
endmodule

// File: rtl/cs_buf_port.sv
module cs_buf_port
    import conv_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              slot_first,
    input  logic              slot_last,
    input  logic              wr_zone,
    input  logic              mem_gnt,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     data_in,
    input  logic [DW-1:0]     aux_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WSEL_W-1:0] wsel,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     ctrl_word,
    output logic              ctrl_upper,
    output logic              overrun
);
    acc_state_t st, st_nx;
    logic       missed;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= AC_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        if (restart || slot_last) begin
            st_nx = AC_IDLE;
        end else begin
            unique case (st)
                AC_IDLE:    if (slot_first) st_nx = AC_RD_CTRL;
                AC_RD_CTRL: if (mem_gnt)    st_nx = AC_RD_UL;
                AC_RD_UL:   if (mem_gnt)    st_nx = AC_WAIT_WR;
                AC_WAIT_WR: if (wr_zone)    st_nx = AC_WR_DATA;
                AC_WR_DATA: if (mem_gnt)    st_nx = AC_WR_AUX;
                AC_WR_AUX:  if (mem_gnt)    st_nx = AC_DONE;
                AC_DONE:                    st_nx = AC_DONE;
                default:                    st_nx = AC_IDLE;
            endcase
        end
    end

    always_comb begin
        missed = slot_last && !restart &&
                 !((st == AC_DONE) || (st == AC_WR_AUX && mem_gnt));
    end

    // captured words and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word  <= '0;
            ctrl_upper <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (missed) begin
                overrun <= 1'b1;
            end
            if (!restart && mem_gnt && st == AC_RD_CTRL) begin
                ctrl_word <= mem_rdata;
            end
            if (!restart && mem_gnt && st == AC_RD_UL) begin
                ctrl_upper <= mem_rdata[0];
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        wsel      = WS_CTRL;
        mem_wdata = '0;
        unique case (st)
            AC_RD_CTRL: begin
                mem_req = 1'b1;
                wsel    = WS_CTRL;
            end
            AC_RD_UL: begin
                mem_req = 1'b1;
                wsel    = WS_UL;
            end
            AC_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                wsel      = WS_DATA;
                mem_wdata = data_in;
            end
            AC_WR_AUX: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                wsel      = WS_AUX;
                mem_wdata = aux_in;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int PRESCALE  = 24,
    parameter int SLOT_CLKS = 833,
    parameter int NUM_SLOTS = 96,
    parameter int WR_WIN    = 16,
    parameter int DW        = 16,
    localparam int TW = $clog2(SLOT_CLKS),
    localparam int SW = $clog2(NUM_SLOTS),
    localparam int AW = 1 + SW + WSEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          field_in,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] data_in,
    input  logic [DW-1:0] aux_in,
    output logic          bit_clk,
    output logic          frame_active,
    output logic [SW-1:0] slot_idx,
    output logic          fill_half,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] ctrl_word,
    output logic          ctrl_upper,
    output logic          overrun
);
    logic              field_q;
    logic              restart;
    logic [TW-1:0]     tick;
    logic              slot_first;
    logic              slot_last;
    logic              wr_zone;
    logic [WSEL_W-1:0] wsel;

    // field edge detect and buffer half toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q   <= 1'b0;
            fill_half <= 1'b0;
        end else begin
            field_q <= field_in;
            if (restart) begin
                fill_half <= ~fill_half;
            end
        end
    end

    always_comb begin
        restart = field_in && !field_q;
    end

    cs_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .bit_clk (bit_clk)
    );

    cs_frame_timer #(
        .SLOT_CLKS (SLOT_CLKS),
        .NUM_SLOTS (NUM_SLOTS),
        .WR_WIN    (WR_WIN)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .tick       (tick),
        .slot       (slot_idx),
        .active     (frame_active),
        .slot_first (slot_first),
        .slot_last  (slot_last),
        .wr_zone    (wr_zone)
    );

    cs_buf_port #(.DW(DW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .slot_first (slot_first),
        .slot_last  (slot_last),
        .wr_zone    (wr_zone),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .data_in    (data_in),
        .aux_in     (aux_in),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .wsel       (wsel),
        .mem_wdata  (mem_wdata),
        .ctrl_word  (ctrl_word),
        .ctrl_upper (ctrl_upper),
        .overrun    (overrun)
    );

    always_comb begin
        mem_addr = {fill_half, slot_idx, wsel};
    end
endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk #(
    parameter int SLOT_CLKS = 833,
    parameter int NUM_SLOTS = 96,
    parameter int WR_WIN    = 16,
    parameter int TW        = 10,
    parameter int SW        = 7,
    parameter int AW        = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          restart,
    input logic          slot_last,
    input logic [TW-1:0] tick,
    input logic [SW-1:0] slot_idx,
    input logic          frame_active,
    input logic          fill_half,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          overrun
);
    localparam logic [TW-1:0] T_WR   = TW'(SLOT_CLKS - WR_WIN);
    localparam logic [SW-1:0] S_LAST = SW'(NUM_SLOTS - 1);

    // R4
    frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |-> !mem_req);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !restart && !slot_last)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (tick > T_WR));

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R5
    half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (fill_half != $past(fill_half)));

    // R5
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(fill_half));

    // R3
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_last && !restart && slot_idx != S_LAST)
        |=> (slot_idx == $past(slot_idx) + 1'b1));

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (frame_active && slot_idx == '0 && tick == '0));
endmodule

bind conv_seq cs_seq_chk #(
    .SLOT_CLKS (SLOT_CLKS),
    .NUM_SLOTS (NUM_SLOTS),
    .WR_WIN    (WR_WIN),
    .TW        (TW),
    .SW        (SW),
    .AW        (AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .slot_last    (slot_last),
    .tick         (tick),
    .slot_idx     (slot_idx),
    .frame_active (frame_active),
    .fill_half    (fill_half),
    .mem_req      (mem_req),
    .mem_gnt      (mem_gnt),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .overrun      (overrun)
);

// File: tb/conv_seq_test.sv
module conv_seq_test;
    localparam int P  = 4;
    localparam int S  = 40;
    localparam int N  = 6;
    localparam int WR = 8;
    localparam int DW = 16;
    localparam int SW = 3;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          field_in = 1'b0;
    logic          mem_gnt = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] aux_in = '0;
    logic          bit_clk, frame_active, fill_half, mem_req, mem_we, ctrl_upper, overrun;
    logic [SW-1:0] slot_idx;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, ctrl_word;

    conv_seq #(.PRESCALE(P), .SLOT_CLKS(S), .NUM_SLOTS(N), .WR_WIN(WR), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .field_in(field_in), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .data_in(data_in), .aux_in(aux_in),
        .bit_clk(bit_clk), .frame_active(frame_active), .slot_idx(slot_idx),
        .fill_half(fill_half), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ctrl_word(ctrl_word),
        .ctrl_upper(ctrl_upper), .overrun(overrun)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    int            n = 0;
    bit            synced = 0;
    bit            fld_prev = 0;
    bit            exp_half = 0;
    bit            exp_ovr = 0;
    bit            exp_upper = 0;
    bit            just_ul = 0;
    int            k = 0;
    logic [DW-1:0] exp_ctrl = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_bitclk(input int cyc);
        return (cyc % P) < (P / 2);
    endfunction

    function automatic logic [AW-1:0] exp_addr(input bit half, input int sl, input int ws);
        return AW'((int'(half) << (SW + 3)) | (sl << 3) | ws);
    endfunction

    // gmode: 0 random grant, 1 always grant, 2 never grant
    task automatic cycle(input bit fld, input int gmode);
        int tk, sl;
        bit act, ereq, g, rise;
        logic [DW-1:0] rd;
        @(negedge clk);
        if (synced) n++;
        tk  = synced ? (n % S) : 0;
        sl  = n / S;
        act = synced && (n < N * S);
        if (act && tk == 0) k = 0;
        if (synced) chk(bit_clk == exp_bitclk(n), "R1 bit_clk", bit_clk, exp_bitclk(n));
        chk(frame_active == act, "R2/R4 frame_active", frame_active, act);
        if (act) chk(slot_idx == SW'(sl), "R3 slot_idx", slot_idx, sl);
        ereq = act && ((k < 2 && tk >= 1) ||
                       (k >= 2 && k < 4 && tk >= S - WR + 1 && !just_ul));
        chk(mem_req == ereq, "R7/R8 mem_req", mem_req, ereq);
        if (mem_req && ereq) begin
            chk(mem_addr == exp_addr(exp_half, sl, k), "R6 mem_addr", mem_addr, exp_addr(exp_half, sl, k));
            chk(mem_we == (k >= 2), "R8 mem_we", mem_we, k >= 2);
            if (k == 2) chk(mem_wdata == data_in, "R8 data word", mem_wdata, data_in);
            if (k == 3) chk(mem_wdata == aux_in, "R8 aux word", mem_wdata, aux_in);
        end
        chk(fill_half == exp_half, "R5 fill_half", fill_half, exp_half);
        chk(overrun == exp_ovr, "R10/R11 overrun", overrun, exp_ovr);
        chk(ctrl_word == exp_ctrl, "R9 ctrl_word", ctrl_word, exp_ctrl);
        chk(ctrl_upper == exp_upper, "R9 ctrl_upper", ctrl_upper, exp_upper);
        just_ul = 0;
        unique case (gmode)
            0:       g = ($urandom % 4) != 0;
            1:       g = 1'b1;
            default: g = 1'b0;
        endcase
        rd   = DW'($urandom);
        rise = fld && !fld_prev;
        if (!rise && ereq && g) begin
            if (k == 0) exp_ctrl = rd;
            if (k == 1) begin
                exp_upper = rd[0];
                just_ul = 1;
            end
            k++;
        end
        if (!rise && act && tk == S - 1 && k < 4) exp_ovr = 1;
        if (rise) begin
            synced = 1;
            n = -1;
            exp_half = !exp_half;
            k = 0;
            just_ul = 0;
        end
        mem_gnt   = g;
        mem_rdata = rd;
        field_in  = fld;
        fld_prev  = fld;
        data_in   = DW'($urandom);
        aux_in    = DW'($urandom);
    endtask

    task automatic frame(input int len, input int gmode, input int hi);
        for (int i = 0; i < len; i++) cycle(i < hi, gmode);
    endtask

    initial begin
        void'($urandom(32'h5eed_1280));
        // reset state
        repeat (3) begin
            @(negedge clk);
            chk(mem_req == 1'b0, "R4 reset mem_req", mem_req, 0);
            chk(overrun == 1'b0, "R10 reset overrun", overrun, 0);
            chk(fill_half == 1'b0, "R5 reset fill_half", fill_half, 0);
            chk(frame_active == 1'b0, "R4 reset frame_active", frame_active, 0);
            chk(ctrl_word == '0, "R9 reset ctrl_word", ctrl_word, 0);
        end
        rst_n = 1'b1;
        // R2: nothing starts without a field edge
        repeat (20) cycle(0, 1);
        // full frames with prompt grants, including the tail
        repeat (3) frame(250, 1, 3);
        // R2: early pulse restarts mid-frame
        frame(100, 1, 2);
        // R2: field held high does not retrigger
        frame(250, 1, 60);
        // R11: restart while a write is pending
        cycle(1, 1);
        repeat (2 * S + 32) cycle(0, 1);
        repeat (3) cycle(0, 2);
        // R10: one slot receives no grant at all
        cycle(1, 1);
        repeat (S) cycle(0, 1);
        repeat (S) cycle(0, 2);
        repeat (170) cycle(0, 1);
        // random grant latency and pulse spacing
        for (int f = 0; f < 20; f++) begin
            frame($urandom_range(262, 245), 0, $urandom_range(4, 1));
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule